// File: doc/BRIEF.md
# Conditional Writeback and Pointer Update Unit

This unit sits at the writeback end of a 16-register, 16-bit core. For each long-form instruction it takes in the 16-bit extension word together with the register values read for it and the ALU result. It decodes the word and evaluates a selectable, invertible condition on one register. That condition decides whether the ALU result is written to the destination. The unit also computes the incremented or decremented values and the access addresses of two pointer registers: the source register named by the basic instruction, and the destination register. A short immediate can replace the second operand, and it can be used in the same instruction as both pointer updates.

Transactions move through one register stage with valid/ready handshakes. A transaction is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and no new transaction is accepted. The two read-index outputs are decoded combinationally from the presented word, so the register file can fetch the tested and destination values in the same cycle.

Extension word layout, from bit 15 down: immediate flag [15], condition select [14:13], negate [12], tested register [11:8], destination register [7:4], source update mode [3:2], destination update mode [1:0].

Top module: `cond_wb_unit`

## Requirements
- R1: `rd_tst_idx` equals extension bits [11:8] and `rd_dst_idx` equals bits [7:4], combinationally. `wa_idx` carries the destination field and `wb_idx` carries `src_idx`.
- R2: The condition select in bits [14:13] chooses the test: 00 is bit 0 of the tested value, 01 is bit 15, 10 is "the whole value equals zero", and 11 is always true. The result appears on `cond_pass`.
- R3: When bit 12 is 1, the selected condition is inverted. Inverted "always" is never true.
- R4: When the condition holds, port A (`wa_en`, `wa_idx`, `wa_data`) writes `alu_res` to the destination register. This applies whatever the destination update mode is.
- R5: When the condition fails, the ALU result is not written, but the source register update still takes place.
- R6: The update modes are encoded as 00 none, 01 post-increment, 10 post-decrement and 11 pre-decrement, with a step of 1 and wrap-around modulo 2^16. The access address (`src_addr`, `dst_addr`) is the updated value for pre-decrement and the original value otherwise. Port B (`wb_en`, `wb_data`) writes the updated source value whenever the source mode is not none.
- R7: When the condition fails and the destination mode is not none, port A writes the updated destination value instead of the result. When the condition fails and the destination mode is none, `wa_en` is 0.
- R8: When port A is enabled and targets the same register as the source update, port B is suppressed.
- R9: When bit 15 is 1, `opb_out` is `opb_field` sign-extended (-8 to +7). Otherwise `opb_out` is `opb_val`. The immediate flag has no effect on the pointer updates.
- R10: The outputs of an accepted transaction appear one clock later with `out_valid` high. While `out_valid` is high and `out_ready` is low, `in_ready` is low and all outputs hold steady.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Unit can accept a transaction |
| ext_word | input | 16 | Extension word |
| src_idx | input | 4 | Source pointer register index from the basic instruction |
| src_val | input | 16 | Value of the source pointer register |
| opb_field | input | 4 | Second-operand field of the basic instruction |
| opb_val | input | 16 | Register value read through the second-operand field |
| dst_val | input | 16 | Value of the destination register |
| tst_val | input | 16 | Value of the tested register |
| alu_res | input | 16 | ALU result |
| rd_tst_idx | output | 4 | Read index for the tested register |
| rd_dst_idx | output | 4 | Read index for the destination register |
| out_valid | output | 1 | Output transaction present |
| out_ready | input | 1 | Consumer accepts the output |
| cond_pass | output | 1 | Evaluated condition |
| opb_out | output | 16 | Effective second operand |
| src_addr | output | 16 | Access address from the source pointer |
| dst_addr | output | 16 | Access address from the destination pointer |
| wa_en | output | 1 | Port A write enable |
| wa_idx | output | 4 | Port A register index |
| wa_data | output | 16 | Port A write data |
| wb_en | output | 1 | Port B write enable |
| wb_idx | output | 4 | Port B register index |
| wb_data | output | 16 | Port B write data |

## Verification
The bench targets the following corner cases:

- **Inverted "always":** a design that ignores the negate bit on this select would write results that should be dropped.
- **Failed condition with a source update:** a design that gates the whole transaction on the condition would lose the pointer step.
- **Pre-decrement versus post modes:** a design that mixes these up would present the wrong access address while still writing the correct register value.
- **Wrap-around at 0 and 0xFFFF:** a design with a wrong width would not wrap correctly.
- **Source and destination on the same register:** a design without collision handling would drive two writes to one register.
- **Negative immediates:** a design that zero-extends would turn -8 into 8.
- **Stalls:** a design that lets outputs move while stalled would lose a transaction.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  typedef enum logic [1:0] {
    COND_LSB    = 2'b00,
    COND_MSB    = 2'b01,
    COND_ZERO   = 2'b10,
    COND_ALWAYS = 2'b11
  } cond_sel_e;

  typedef enum logic [1:0] {
    UPD_NONE     = 2'b00,
    UPD_POST_INC = 2'b01,
    UPD_POST_DEC = 2'b10,
    UPD_PRE_DEC  = 2'b11
  } upd_mode_e;

  localparam int COND_W = 2;
  localparam int MODE_W = 2;
endpackage

// File: rtl/cwb_ext_decode.sv
module cwb_ext_decode
  import cwb_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int EXT_W = 1 + COND_W + 1 + 2*IDX_W + 2*MODE_W
) (
  input  logic [EXT_W-1:0] ext,
  output logic             imm_flag,
  output cond_sel_e        cond_sel,
  output logic             negate,
  output logic [IDX_W-1:0] tst_idx,
  output logic [IDX_W-1:0] dst_idx,
  output upd_mode_e        src_mode,
  output upd_mode_e        dst_mode
);
  // Field positions, counted from bit 0 upward
  localparam int DM_LO  = 0;
  localparam int SM_LO  = DM_LO + MODE_W;
  localparam int DST_LO = SM_LO + MODE_W;
  localparam int TST_LO = DST_LO + IDX_W;
  localparam int NEG_B  = TST_LO + IDX_W;
  localparam int CS_LO  = NEG_B + 1;
  localparam int IMM_B  = CS_LO + COND_W;

  always_comb begin
    imm_flag = ext[IMM_B];
    cond_sel = cond_sel_e'(ext[CS_LO +: COND_W]);
    negate   = ext[NEG_B];
    tst_idx  = ext[TST_LO +: IDX_W];
    dst_idx  = ext[DST_LO +: IDX_W];
    src_mode = upd_mode_e'(ext[SM_LO +: MODE_W]);
    dst_mode = upd_mode_e'(ext[DM_LO +: MODE_W]);
  end
endmodule

// File: rtl/cwb_cond_eval.sv
module cwb_cond_eval
  import cwb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  cond_sel_e         sel,
  input  logic              negate,
  input  logic [DATA_W-1:0] tst_val,
  output logic              pass
);
  logic raw;

  always_comb begin
    unique case (sel)
      COND_LSB:    raw = tst_val[0];
      COND_MSB:    raw = tst_val[DATA_W-1];
      COND_ZERO:   raw = (tst_val == '0);
      default:     raw = 1'b1;
    endcase
    pass = raw ^ negate;
  end

  // R3: the always select yields exactly the inverse of the negate bit
  always_comb begin
    if (sel == COND_ALWAYS) begin
      a_r3_always_inverts: assert (pass == !negate);
    end
  end
endmodule

// File: rtl/cwb_ptr_update.sv
module cwb_ptr_update
  import cwb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STEP   = 1
) (
  input  upd_mode_e         mode,
  input  logic [DATA_W-1:0] cur,
  output logic              upd_en,
  output logic [DATA_W-1:0] next_val,
  output logic [DATA_W-1:0] addr
);
  localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

  logic [DATA_W-1:0] plus_v;
  logic [DATA_W-1:0] minus_v;

  assign plus_v  = cur + STEP_V;
  assign minus_v = cur - STEP_V;

  always_comb begin
    upd_en   = (mode != UPD_NONE);
    next_val = cur;
    addr     = cur;
    unique case (mode)
      UPD_POST_INC: next_val = plus_v;
      UPD_POST_DEC: next_val = minus_v;
      UPD_PRE_DEC: begin
        next_val = minus_v;
        addr     = minus_v;
      end
      default: ;
    endcase
  end

  // R6: a stepped pointer always moves, and only pre-decrement exposes the new value
  always_comb begin
    if (upd_en) begin
      a_r6_step_moves: assert (next_val != cur);
      a_r6_addr_choice: assert ((addr == next_val) == (mode == UPD_PRE_DEC));
    end
  end
endmodule

// File: rtl/cwb_out_stage.sv
module cwb_out_stage #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_pay,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_pay
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pay   <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_pay   <= in_pay;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R10: a stalled output holds its content
  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pay)));

  // R10: an accepted transaction is presented on the next cycle
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/cond_wb_unit.sv
module cond_wb_unit
  import cwb_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 16,
  parameter int IMM_W   = 4,
  parameter int STEP    = 1,
  localparam int IDX_W  = $clog2(REG_CNT),
  localparam int EXT_W  = 1 + COND_W + 1 + 2*IDX_W + 2*MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [EXT_W-1:0]  ext_word,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [DATA_W-1:0] src_val,
  input  logic [IMM_W-1:0]  opb_field,
  input  logic [DATA_W-1:0] opb_val,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] tst_val,
  input  logic [DATA_W-1:0] alu_res,
  output logic [IDX_W-1:0]  rd_tst_idx,
  output logic [IDX_W-1:0]  rd_dst_idx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              cond_pass,
  output logic [DATA_W-1:0] opb_out,
  output logic [DATA_W-1:0] src_addr,
  output logic [DATA_W-1:0] dst_addr,
  output logic              wa_en,
  output logic [IDX_W-1:0]  wa_idx,
  output logic [DATA_W-1:0] wa_data,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data
);
  localparam int PAY_W = 3 + 5*DATA_W + 2*IDX_W;

  logic             imm_flag, negate, pass_c;
  cond_sel_e        cond_sel;
  upd_mode_e        src_mode, dst_mode;
  logic [IDX_W-1:0] tst_idx, dst_idx;

  cwb_ext_decode #(.IDX_W(IDX_W)) u_dec (
    .ext(ext_word), .imm_flag(imm_flag), .cond_sel(cond_sel), .negate(negate),
    .tst_idx(tst_idx), .dst_idx(dst_idx), .src_mode(src_mode), .dst_mode(dst_mode)
  );

  assign rd_tst_idx = tst_idx;
  assign rd_dst_idx = dst_idx;

  cwb_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .sel(cond_sel), .negate(negate), .tst_val(tst_val), .pass(pass_c)
  );

  // Two pointer updaters: index 0 source, index 1 destination
  upd_mode_e         p_mode [2];
  logic [DATA_W-1:0] p_cur  [2];
  logic              p_en   [2];
  logic [DATA_W-1:0] p_next [2];
  logic [DATA_W-1:0] p_addr [2];

  assign p_mode[0] = src_mode;
  assign p_mode[1] = dst_mode;
  assign p_cur[0]  = src_val;
  assign p_cur[1]  = dst_val;

  for (genvar g = 0; g < 2; g++) begin : g_ptr
    cwb_ptr_update #(.DATA_W(DATA_W), .STEP(STEP)) u_upd (
      .mode(p_mode[g]), .cur(p_cur[g]), .upd_en(p_en[g]),
      .next_val(p_next[g]), .addr(p_addr[g])
    );
  end

  logic [DATA_W-1:0] imm_sx, opb_c, wa_data_c;
  logic              wa_en_c, wb_en_c;

  assign imm_sx = {{(DATA_W-IMM_W){opb_field[IMM_W-1]}}, opb_field};
  assign opb_c  = imm_flag ? imm_sx : opb_val;

  always_comb begin
    // Port A: result on a passed condition, else the destination pointer step
    wa_en_c   = pass_c || p_en[1];
    wa_data_c = pass_c ? alu_res : p_next[1];
    // Port B: source pointer step, yielding to port A on the same register
    wb_en_c   = p_en[0] && !(wa_en_c && (src_idx == dst_idx));
  end

  logic [PAY_W-1:0] pay_in, pay_out;

  assign pay_in = {pass_c, opb_c, p_addr[0], p_addr[1],
                   wa_en_c, dst_idx, wa_data_c,
                   wb_en_c, src_idx, p_next[0]};

  cwb_out_stage #(.PAY_W(PAY_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pay(pay_in), .out_valid(out_valid), .out_ready(out_ready), .out_pay(pay_out)
  );

  assign {cond_pass, opb_out, src_addr, dst_addr,
          wa_en, wa_idx, wa_data,
          wb_en, wb_idx, wb_data} = pay_out;

  // R8: the two write ports never target one register together
  a_r8_ports_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wa_en && wb_en) |-> (wa_idx != wb_idx));

  // R4: a passed condition always produces a port A write
  a_r4_pass_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cond_pass) |-> wa_en);

  // R10: a stalled handshake refuses new input
  a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/tb_cond_wb_unit.sv
module tb_cond_wb_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0, out_ready = 1;
  logic [15:0] ext_word = 0, src_val = 0, opb_val = 0, dst_val = 0, tst_val = 0, alu_res = 0;
  logic [3:0]  src_idx = 0, opb_field = 0;
  logic        in_ready, out_valid, cond_pass, wa_en, wb_en;
  logic [3:0]  rd_tst_idx, rd_dst_idx, wa_idx, wb_idx;
  logic [15:0] opb_out, src_addr, dst_addr, wa_data, wb_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cond_wb_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .ext_word(ext_word), .src_idx(src_idx), .src_val(src_val),
    .opb_field(opb_field), .opb_val(opb_val), .dst_val(dst_val),
    .tst_val(tst_val), .alu_res(alu_res), .rd_tst_idx(rd_tst_idx),
    .rd_dst_idx(rd_dst_idx), .out_valid(out_valid), .out_ready(out_ready),
    .cond_pass(cond_pass), .opb_out(opb_out), .src_addr(src_addr),
    .dst_addr(dst_addr), .wa_en(wa_en), .wa_idx(wa_idx), .wa_data(wa_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(bit imm, bit [1:0] cs, bit ng, bit [3:0] t,
                                     bit [3:0] d, bit [1:0] sm, bit [1:0] dm);
    return {imm, cs, ng, t, d, sm, dm};
  endfunction

  // Requirement model: mode 01 +1, 10 -1, 11 -1 (address follows), 00 unchanged
  function automatic logic [15:0] nxt(bit [1:0] m, logic [15:0] v);
    return (m == 2'b01) ? v + 16'd1 : (m == 2'b00) ? v : v - 16'd1;
  endfunction
  function automatic logic [15:0] adr(bit [1:0] m, logic [15:0] v);
    return (m == 2'b11) ? v - 16'd1 : v;
  endfunction

  logic [15:0] e_wa_data, e_opb;
  logic        e_pass, e_wa_en, e_wb_en;

  task automatic model(logic [15:0] w);
    bit c;
    case (w[14:13])
      2'b00: c = tst_val[0];
      2'b01: c = tst_val[15];
      2'b10: c = (tst_val == 16'd0);
      default: c = 1'b1;
    endcase
    e_pass    = c ^ w[12];
    e_wa_en   = e_pass || (w[1:0] != 2'b00);
    e_wa_data = e_pass ? alu_res : nxt(w[1:0], dst_val);
    e_wb_en   = (w[3:2] != 2'b00) && !(e_wa_en && src_idx == w[7:4]);
    e_opb     = w[15] ? {{12{opb_field[3]}}, opb_field} : opb_val;
  endtask

  task automatic run_case(string req, logic [15:0] w, logic [3:0] si, logic [15:0] sv,
                          logic [3:0] of, logic [15:0] ov, logic [15:0] dv,
                          logic [15:0] tv, logic [15:0] res);
    @(negedge clk);
    ext_word = w; src_idx = si; src_val = sv; opb_field = of; opb_val = ov;
    dst_val = dv; tst_val = tv; alu_res = res; in_valid = 1;
    model(w);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk(req, "out_valid", 16'(out_valid), 16'd1);
    chk(req, "cond_pass", 16'(cond_pass), 16'(e_pass));
    chk(req, "wa_en", 16'(wa_en), 16'(e_wa_en));
    if (e_wa_en) begin
      chk(req, "wa_idx", 16'(wa_idx), 16'(w[7:4]));
      chk(req, "wa_data", wa_data, e_wa_data);
    end
    chk(req, "wb_en", 16'(wb_en), 16'(e_wb_en));
    if (e_wb_en) begin
      chk(req, "wb_idx", 16'(wb_idx), 16'(si));
      chk(req, "wb_data", wb_data, nxt(w[3:2], sv));
    end
    chk(req, "src_addr", src_addr, adr(w[3:2], sv));
    chk(req, "dst_addr", dst_addr, adr(w[1:0], dv));
    chk(req, "opb_out", opb_out, e_opb);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11", "out_valid", 16'(out_valid), 16'd0);
    chk("R11", "in_ready", 16'(in_ready), 16'd1);
  endtask

  task automatic t_decode;
    @(negedge clk);
    ext_word = mk(0, 2'b11, 0, 4'hA, 4'h5, 2'b00, 2'b00);
    #1;
    chk("R1", "rd_tst_idx", 16'(rd_tst_idx), 16'hA);
    chk("R1", "rd_dst_idx", 16'(rd_dst_idx), 16'h5);
  endtask

  task automatic t_cond_kinds;
    run_case("R2", mk(0, 2'b00, 0, 1, 2, 0, 0), 3, 16'h10, 0, 0, 0, 16'h0001, 16'h1111);
    run_case("R2", mk(0, 2'b00, 0, 1, 2, 0, 0), 3, 16'h10, 0, 0, 0, 16'hFFFE, 16'h1111);
    run_case("R2", mk(0, 2'b01, 0, 1, 2, 0, 0), 3, 16'h10, 0, 0, 0, 16'h8000, 16'h2222);
    run_case("R2", mk(0, 2'b01, 0, 1, 2, 0, 0), 3, 16'h10, 0, 0, 0, 16'h7FFF, 16'h2222);
    run_case("R2", mk(0, 2'b10, 0, 1, 2, 0, 0), 3, 16'h10, 0, 0, 0, 16'h0000, 16'h3333);
    run_case("R2", mk(0, 2'b10, 0, 1, 2, 0, 0), 3, 16'h10, 0, 0, 0, 16'h0100, 16'h3333);
    run_case("R4", mk(0, 2'b11, 0, 1, 7, 0, 2'b01), 3, 16'h10, 0, 0, 16'h40, 16'h0, 16'h4444);
  endtask

  task automatic t_negate;
    run_case("R3", mk(0, 2'b11, 1, 1, 2, 0, 0), 3, 16'h10, 0, 0, 0, 16'h0, 16'h5555);
    run_case("R3", mk(0, 2'b10, 1, 1, 2, 0, 0), 3, 16'h10, 0, 0, 0, 16'h0, 16'h5555);
    run_case("R3", mk(0, 2'b00, 1, 1, 2, 0, 0), 3, 16'h10, 0, 0, 0, 16'h2, 16'h5555);
  endtask

  task automatic t_modes;
    run_case("R6", mk(0, 2'b11, 0, 0, 2, 2'b01, 0), 4, 16'hFFFF, 0, 0, 0, 0, 16'h6);
    run_case("R6", mk(0, 2'b11, 0, 0, 2, 2'b10, 0), 4, 16'h0000, 0, 0, 0, 0, 16'h6);
    run_case("R6", mk(0, 2'b11, 0, 0, 2, 2'b11, 0), 4, 16'h0100, 0, 0, 0, 0, 16'h6);
    run_case("R6", mk(0, 2'b11, 0, 0, 2, 2'b11, 2'b11), 4, 16'h0100, 0, 0, 16'h0200, 0, 16'h6);
  endtask

  task automatic t_false;
    run_case("R5", mk(0, 2'b11, 1, 0, 2, 2'b01, 0), 4, 16'h1234, 0, 0, 0, 0, 16'h7777);
    run_case("R7", mk(0, 2'b11, 1, 0, 2, 2'b10, 2'b01), 4, 16'h1234, 0, 0, 16'h0050, 0, 16'h7777);
    run_case("R7", mk(0, 2'b11, 1, 0, 2, 0, 2'b11), 4, 16'h1234, 0, 0, 16'h0000, 0, 16'h7777);
  endtask

  task automatic t_collide;
    run_case("R8", mk(0, 2'b11, 0, 0, 6, 2'b01, 0), 6, 16'h0020, 0, 0, 16'h0099, 0, 16'h8888);
    run_case("R8", mk(0, 2'b11, 1, 0, 6, 2'b01, 0), 6, 16'h0020, 0, 0, 16'h0099, 0, 16'h8888);
    run_case("R8", mk(0, 2'b11, 1, 0, 6, 2'b01, 2'b10), 6, 16'h0020, 0, 0, 16'h0099, 0, 16'h8888);
  endtask

  task automatic t_imm;
    run_case("R9", mk(1, 2'b11, 0, 0, 2, 2'b01, 2'b11), 5, 16'h0030, 4'h8, 16'hABCD, 16'h0060, 0, 16'h9);
    run_case("R9", mk(1, 2'b11, 0, 0, 2, 0, 0), 5, 16'h0030, 4'h7, 16'hABCD, 0, 0, 16'h9);
    run_case("R9", mk(0, 2'b11, 0, 0, 2, 0, 0), 5, 16'h0030, 4'h8, 16'hABCD, 0, 0, 16'h9);
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 0;
    ext_word = mk(0, 2'b11, 0, 0, 3, 0, 0); alu_res = 16'hAAAA; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    alu_res = 16'hBBBB; ext_word = mk(0, 2'b11, 0, 0, 9, 0, 0);
    chk("R10", "in_ready stalled", 16'(in_ready), 16'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R10", "held out_valid", 16'(out_valid), 16'd1);
    chk("R10", "held wa_data", wa_data, 16'hAAAA);
    chk("R10", "held wa_idx", 16'(wa_idx), 16'd3);
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk("R10", "next wa_data", wa_data, 16'hBBBB);
    chk("R10", "next wa_idx", 16'(wa_idx), 16'd9);
    @(posedge clk);
    @(negedge clk);
    chk("R10", "drained", 16'(out_valid), 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_reset;
    t_decode;
    t_cond_kinds;
    t_negate;
    t_modes;
    t_false;
    t_collide;
    t_imm;
    t_stall;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule